// File: doc/BRIEF.md
# PLL Scan-Chain Reconfiguration Controller

This block loads a new counter configuration into a PLL through the PLL's serial scan chain. A requester presents a parallel configuration word and pulses a start input. The controller raises the scan clock enable, waits one lead cycle, and then streams the word out one bit per cycle, highest index first. It drops the enable once the last bit has gone out and issues a single-cycle update strobe that tells the PLL to take the chain contents into its counters.

After the strobe, the controller watches the PLL's done line. The PLL raises this line when reprogramming starts and lowers it when the new settings are in place. Changes to the multiply, divide, charge-pump or loop-filter settings also require a PLL reset. For these the requester sets a flag alongside start, and the controller then drives a reset pulse of parameterised width once done has fallen. A busy output covers the whole sequence. If done never rises, a timeout returns the block to idle and flags an error. The sequence can be run any number of times.

The chain length is 234 bits or 180 bits, depending on where the PLL sits, and a parameter picks between them. All logic runs on the scan clock and uses a synchronous active-high reset.

Top module: `pll_scan_reconfig`

## Requirements
- R1: When start is accepted, scan enable rises on the next cycle. It is high for one full lead cycle before any data bit is presented, and it stays high for exactly CHAIN_LEN+1 consecutive cycles.
- R2: Data bits are presented one per cycle, starting on the cycle after the lead cycle, in the order word[CHAIN_LEN-1] first down to word[0]. A chain that captures on the second and later rising edges with enable high therefore ends up holding the word with the same bit indices.
- R3: CHAIN_LEN is 234 when SIDE_PLL is 0 (the default) and 180 when SIDE_PLL is 1. Exactly CHAIN_LEN bits are shifted per sequence.
- R4: Scan enable falls in the cycle after the last bit, and no further shift occurs until the next accepted start.
- R5: The update strobe is high for exactly one cycle per sequence. That cycle immediately follows the last enable cycle, and scan enable is low during it.
- R6: Busy is high from the cycle after an accepted start until done has risen and then fallen, and it stays high while done is high. Without a reset request, busy is low in the cycle after done falls.
- R7: If the reset request was high when start was accepted, the PLL reset output is high for exactly RST_PULSE cycles (default 4), starting in the cycle after done falls, and busy stays high throughout. If the request was low, no reset pulse is produced.
- R8: Sequences can be repeated back to back, and each one applies its own word.
- R9: A start pulse while busy is high is ignored. It does not change the word being shifted and does not cause a second update strobe.
- R10: If done does not rise within DONE_TIMEOUT cycles after the update strobe, error is high for one cycle, the block returns to idle (busy low), and no reset pulse is produced.
- R11: After reset, busy, scan enable, scan data, update, PLL reset and error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a reconfiguration; accepted only when idle |
| cfg_i | input | CHAIN_LEN | Configuration word, sampled when start is accepted |
| pll_rst_req_i | input | 1 | A PLL reset is needed after this update; sampled with start |
| scan_done_i | input | 1 | Done line from the PLL: rises when reprogramming begins, falls when it ends |
| scan_en_o | output | 1 | Scan clock enable to the PLL |
| scan_data_o | output | 1 | Serial data into the scan chain |
| cfg_update_o | output | 1 | One-cycle strobe that loads the chain into the PLL counters |
| pll_reset_o | output | 1 | Reset pulse to the PLL |
| busy_o | output | 1 | A sequence is in progress |
| error_o | output | 1 | One-cycle pulse when the done rising edge times out |

## Verification
The bench attaches a behavioural scan chain and PLL that capture data only on the second and later enable-high edges. It then compares the captured chain with the requested word for several patterns. A single 1 at the top index and a single 1 at the bottom index catch reversed bit order and off-by-one framing. An alternating pattern catches a dropped or duplicated bit. Random words cover the general case. Runs with and without a reset request separate the two endings of the sequence. A PLL model that never answers drives the timeout path. A start pulse issued mid-shift shows whether a busy request can corrupt the running word.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_UPDATE,
      ST_WRISE,
      ST_WFALL,
      ST_PRST
   } scan_state_e;

   localparam int unsigned LEN_CORNER = 234;
   localparam int unsigned LEN_SIDE   = 180;

   function automatic int unsigned chain_len(input bit side_pll);
      return side_pll ? LEN_SIDE : LEN_CORNER;
   endfunction

endpackage

// File: rtl/pll_scan_shifter.sv
module pll_scan_shifter #(
   parameter int unsigned LEN = 234
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load_i,
   input  logic [LEN-1:0] word_i,
   input  logic           shift_i,
   output logic           bit_o,
   output logic           last_o
);
   localparam int unsigned CW = $clog2(LEN + 1);

   generate
      if (LEN < 2) begin : g_bad_len
         $error("pll_scan_shifter: LEN must be at least 2");
      end
   endgenerate

   logic [LEN-1:0] sh_q;
   logic [CW-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         sh_q  <= word_i;
         cnt_q <= '0;
      end else if (shift_i) begin
         sh_q  <= {sh_q[LEN-2:0], 1'b0};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign bit_o  = sh_q[LEN-1];
   assign last_o = (cnt_q == CW'(LEN - 1));

endmodule

// File: rtl/pll_scan_done_mon.sv
module pll_scan_done_mon #(
   parameter int unsigned TIMEOUT = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic arm_i,
   input  logic done_i,
   output logic rise_o,
   output logic fall_o,
   output logic expired_o
);
   localparam int unsigned TW = $clog2(TIMEOUT + 1);

   generate
      if (TIMEOUT < 2) begin : g_bad_to
         $error("pll_scan_done_mon: TIMEOUT must be at least 2");
      end
   endgenerate

   logic          done_q;
   logic [TW-1:0] timer_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q  <= 1'b0;
         timer_q <= '0;
      end else begin
         done_q  <= done_i;
         timer_q <= arm_i ? timer_q + 1'b1 : '0;
      end
   end

   assign rise_o    = done_i & ~done_q;
   assign fall_o    = ~done_i & done_q;
   assign expired_o = arm_i & ~rise_o & (timer_q == TW'(TIMEOUT - 1));

endmodule

// File: rtl/pll_scan_pulse_timer.sv
module pll_scan_pulse_timer #(
   parameter int unsigned WIDTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic last_o
);
   localparam int unsigned PW = $clog2(WIDTH + 1);

   generate
      if (WIDTH < 1) begin : g_bad_w
         $error("pll_scan_pulse_timer: WIDTH must be at least 1");
      end
   endgenerate

   logic [PW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run_i) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = run_i & (cnt_q == PW'(WIDTH - 1));

endmodule

// File: rtl/pll_scan_reconfig.sv
module pll_scan_reconfig
   import pll_scan_pkg::*;
#(
   parameter bit          SIDE_PLL     = 1'b0,
   parameter int unsigned RST_PULSE    = 4,
   parameter int unsigned DONE_TIMEOUT = 1024,
   localparam int unsigned CHAIN_LEN   = chain_len(SIDE_PLL)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start_i,
   input  logic [CHAIN_LEN-1:0] cfg_i,
   input  logic                 pll_rst_req_i,
   input  logic                 scan_done_i,
   output logic                 scan_en_o,
   output logic                 scan_data_o,
   output logic                 cfg_update_o,
   output logic                 pll_reset_o,
   output logic                 busy_o,
   output logic                 error_o
);
   scan_state_e state_q, state_d;
   logic        need_rst_q;
   logic        err_q, err_d;
   logic        accept;
   logic        sh_bit, sh_last;
   logic        d_rise, d_fall, d_expired;
   logic        p_last;

   assign accept = (state_q == ST_IDLE) && start_i;

   pll_scan_shifter #(.LEN(CHAIN_LEN)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .load_i  (accept),
      .word_i  (cfg_i),
      .shift_i (state_q == ST_SHIFT),
      .bit_o   (sh_bit),
      .last_o  (sh_last)
   );

   pll_scan_done_mon #(.TIMEOUT(DONE_TIMEOUT)) u_done (
      .clk       (clk),
      .rst       (rst),
      .arm_i     (state_q == ST_WRISE),
      .done_i    (scan_done_i),
      .rise_o    (d_rise),
      .fall_o    (d_fall),
      .expired_o (d_expired)
   );

   pll_scan_pulse_timer #(.WIDTH(RST_PULSE)) u_pulse (
      .clk    (clk),
      .rst    (rst),
      .run_i  (state_q == ST_PRST),
      .last_o (p_last)
   );

   always_comb begin
      state_d = state_q;
      err_d   = 1'b0;
      unique case (state_q)
         ST_IDLE:   if (start_i) state_d = ST_LEAD;
         ST_LEAD:   state_d = ST_SHIFT;
         ST_SHIFT:  if (sh_last) state_d = ST_UPDATE;
         ST_UPDATE: state_d = ST_WRISE;
         ST_WRISE: begin
            if (d_rise) state_d = ST_WFALL;
            else if (d_expired) begin
               state_d = ST_IDLE;
               err_d   = 1'b1;
            end
         end
         ST_WFALL:  if (d_fall) state_d = need_rst_q ? ST_PRST : ST_IDLE;
         ST_PRST:   if (p_last) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_IDLE;
         need_rst_q <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
         if (accept) need_rst_q <= pll_rst_req_i;
      end
   end

   assign scan_en_o    = (state_q == ST_LEAD) || (state_q == ST_SHIFT);
   assign scan_data_o  = (state_q == ST_SHIFT) && sh_bit;
   assign cfg_update_o = (state_q == ST_UPDATE);
   assign pll_reset_o  = (state_q == ST_PRST);
   assign busy_o       = (state_q != ST_IDLE);
   assign error_o      = err_q;

endmodule

// File: rtl/pll_scan_reconfig_chk.sv
module pll_scan_reconfig_chk (
   input logic clk,
   input logic rst,
   input logic start_i,
   input logic scan_done_i,
   input logic scan_en_o,
   input logic cfg_update_o,
   input logic pll_reset_o,
   input logic busy_o,
   input logic error_o
);
   // enable only rises right after a start taken while idle
   p_en_from_start_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(scan_en_o) |-> $past(start_i && !busy_o));

   // enable has a lead cycle: never a single-cycle enable
   p_en_lead_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(scan_en_o) |=> scan_en_o);

   p_upd_one_r5: assert property (@(posedge clk) disable iff (rst)
      cfg_update_o |=> !cfg_update_o);

   p_upd_no_en_r4: assert property (@(posedge clk) disable iff (rst)
      cfg_update_o |-> !scan_en_o);

   p_upd_after_shift_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(cfg_update_o) |-> $past(scan_en_o));

   p_rst_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(pll_reset_o) |-> (!$past(scan_done_i) && $past(scan_done_i, 2)));

   p_rst_busy_r7: assert property (@(posedge clk) disable iff (rst)
      pll_reset_o |-> busy_o);

   p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
      error_o |-> (!busy_o && !pll_reset_o));

   p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      error_o |=> !error_o);

endmodule

bind pll_scan_reconfig pll_scan_reconfig_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .start_i      (start_i),
   .scan_done_i  (scan_done_i),
   .scan_en_o    (scan_en_o),
   .cfg_update_o (cfg_update_o),
   .pll_reset_o  (pll_reset_o),
   .busy_o       (busy_o),
   .error_o      (error_o)
);

// File: tb/sim_pll_scan_reconfig.sv
module sim_pll_scan_reconfig;
   localparam int N       = 234;
   localparam int RST_W   = 4;
   localparam int TMO     = 32;
   localparam int RISE_DL = 5;
   localparam int HOLD    = 6;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start_i = 1'b0;
   logic [N-1:0] cfg_i = '0;
   logic         pll_rst_req_i = 1'b0;
   logic         scan_done_i;
   logic         scan_en_o, scan_data_o, cfg_update_o, pll_reset_o, busy_o, error_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   pll_scan_reconfig #(.SIDE_PLL(1'b0), .RST_PULSE(RST_W), .DONE_TIMEOUT(TMO)) u0 (
      .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_i),
      .pll_rst_req_i(pll_rst_req_i), .scan_done_i(scan_done_i),
      .scan_en_o(scan_en_o), .scan_data_o(scan_data_o), .cfg_update_o(cfg_update_o),
      .pll_reset_o(pll_reset_o), .busy_o(busy_o), .error_o(error_o));

   // behavioural scan chain and PLL
   logic         done_en = 1'b1;
   logic         mon_clr = 1'b1;
   logic [N-1:0] chain, applied;
   logic         en_d, mdone;
   int           mphase, dcnt, shift_cnt;
   int           en_cyc, upd_cyc, prst_cyc, err_cyc, bad_busy, bad_order, bad_upd;

   assign scan_done_i = mdone;

   always @(posedge clk) begin
      if (rst) begin
         chain <= '0; applied <= '0; en_d <= 1'b0; mdone <= 1'b0;
         mphase <= 0; dcnt <= 0; shift_cnt <= 0;
      end else begin
         en_d <= scan_en_o;
         if (scan_en_o && en_d) begin
            chain     <= {chain[N-2:0], scan_data_o};
            shift_cnt <= mon_clr ? 0 : shift_cnt + 1;
         end else if (mon_clr) shift_cnt <= 0;
         if (cfg_update_o) begin
            applied <= chain;
            if (done_en) begin mphase <= 1; dcnt <= RISE_DL; end
         end else if (mphase == 1) begin
            if (dcnt == 0) begin mdone <= 1'b1; mphase <= 2; dcnt <= HOLD; end
            else dcnt <= dcnt - 1;
         end else if (mphase == 2) begin
            if (dcnt == 0) begin mdone <= 1'b0; mphase <= 0; end
            else dcnt <= dcnt - 1;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mon_clr) begin
         en_cyc <= 0; upd_cyc <= 0; prst_cyc <= 0; err_cyc <= 0;
         bad_busy <= 0; bad_order <= 0; bad_upd <= 0;
      end else begin
         en_cyc   <= en_cyc + int'(scan_en_o);
         upd_cyc  <= upd_cyc + int'(cfg_update_o);
         prst_cyc <= prst_cyc + int'(pll_reset_o);
         err_cyc  <= err_cyc + int'(error_o);
         if ((pll_reset_o || mdone) && !busy_o) bad_busy <= bad_busy + 1;
         if (pll_reset_o && mdone) bad_order <= bad_order + 1;
         if (cfg_update_o && scan_en_o) bad_upd <= bad_upd + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // run one sequence and check its outcome
   task automatic run_seq(input logic [N-1:0] w, input bit rq, input bit answer,
                          input bit poke_busy, input string tag);
      int guard;
      logic [N-1:0] other;
      @(negedge clk);
      mon_clr = 1'b1; done_en = answer;
      @(negedge clk);
      mon_clr = 1'b0;
      start_i = 1'b1; cfg_i = w; pll_rst_req_i = rq;
      @(negedge clk);
      start_i = 1'b0; cfg_i = '0; pll_rst_req_i = 1'b0;
      if (poke_busy) begin
         repeat (20) @(negedge clk);
         other = ~w;
         start_i = 1'b1; cfg_i = other; pll_rst_req_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0; cfg_i = '0; pll_rst_req_i = 1'b0;
      end
      guard = 0;
      while (busy_o && guard < 3000) begin @(negedge clk); guard++; end
      chk(!busy_o, "R6", {tag, " busy released"}, longint'(busy_o), 0);
      @(negedge clk);
      if (answer) begin
         chk(applied == w, "R2", {tag, " chain holds word"}, longint'(applied[63:0]), longint'(w[63:0]));
         chk(shift_cnt == N, "R3", {tag, " bits shifted"}, shift_cnt, N);
         chk(en_cyc == N + 1, "R1", {tag, " enable cycles"}, en_cyc, N + 1);
         chk(err_cyc == 0, "R10", {tag, " no error"}, err_cyc, 0);
         chk(bad_busy == 0, "R6", {tag, " busy while done/reset"}, bad_busy, 0);
      end else begin
         chk(err_cyc == 1, "R10", {tag, " timeout error pulse"}, err_cyc, 1);
      end
      chk(upd_cyc == 1, "R5", {tag, " update cycles"}, upd_cyc, 1);
      chk(bad_upd == 0, "R4", {tag, " enable low at update"}, bad_upd, 0);
      chk(prst_cyc == ((rq && answer) ? RST_W : 0), "R7", {tag, " reset pulse width"},
          prst_cyc, (rq && answer) ? RST_W : 0);
      chk(bad_order == 0, "R7", {tag, " reset after done fall"}, bad_order, 0);
      chk(!pll_reset_o && !error_o && !scan_en_o, "R6", {tag, " idle outputs"},
          {pll_reset_o, error_o, scan_en_o}, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!busy_o && !scan_en_o && !scan_data_o, "R11", "busy/en/data after reset",
          {busy_o, scan_en_o, scan_data_o}, 0);
      chk(!cfg_update_o && !pll_reset_o && !error_o, "R11", "update/reset/error after reset",
          {cfg_update_o, pll_reset_o, error_o}, 0);
   endtask

   task automatic t_ignore_busy();
      logic [N-1:0] w;
      for (int i = 0; i < N; i++) w[i] = 1'($urandom);
      // R9: second start mid-shift carries ~w and a reset request; both must be ignored
      run_seq(w, 1'b0, 1'b1, 1'b1, "R9 busy start");
   endtask

   initial begin
      logic [N-1:0] w;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      w = '0; w[N-1] = 1'b1;
      run_seq(w, 1'b0, 1'b1, 1'b0, "top bit");
      w = '0; w[0] = 1'b1;
      run_seq(w, 1'b1, 1'b1, 1'b0, "bottom bit with reset");
      for (int i = 0; i < N; i++) w[i] = i[0];
      run_seq(w, 1'b0, 1'b1, 1'b0, "alternating");
      // R8: back-to-back random words
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < N; i++) w[i] = 1'($urandom);
         run_seq(w, k[0], 1'b1, 1'b0, "R8 repeat");
      end
      t_ignore_busy();
      w = '1;
      run_seq(w, 1'b1, 1'b0, 1'b0, "R10 no done");
      w = '0; w[N/2] = 1'b1;
      run_seq(w, 1'b0, 1'b1, 1'b0, "R8 after timeout");
      finish_run();
   end

   initial begin
      wait (cycles > 150000);
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      finish_run();
   end

endmodule